// File: doc/BRIEF.md
# Transmit Schedule Command Sequencer

This block executes a small program of 16-bit commands fetched from a 512-entry schedule memory. The commands control a serial word transmitter. A command can send a 32-bit message word, wait for a gap measured in line bit periods, wait for a resume pulse, raise a one-cycle interrupt, jump to another schedule address, or halt. Message and gap commands carry an 8-bit index into a 256-entry by 32-bit message memory. That entry holds either the data word to send or a 20-bit gap time.

The block has two elapsed-time counters that advance on a bit-period tick input. One counts from the end of the latest transmission, the other from its start. A plain gap is measured from the end of the previous word. A fixed gap is measured from its start, which gives a constant start-to-start period. Because the tick input sets the time base, one design serves every line rate. A gap time of 4 or less is rejected: the program halts and a sticky error flag is raised. Both memories are read with a registered address and return data one cycle later.

Top module: `tsq_sequencer`

## Requirements
- R1: While reset is held and after reset, `running_o`, `tx_req_o`, `irq_o` and `error_o` are all low.
- R2: A `start_i` pulse while idle starts execution at schedule address 0. The program counter then advances by one per command. A command with bits 15..12 = 0001 sends the 32-bit message-memory word at the index in bits 7..0: `tx_req_o` rises with that word on `tx_word_o`, and both are held until `tx_done_i`.
- R3: Bits 15..12 = 0000 (halt), 0111, or any word with bit 15 set ends execution, and `running_o` falls.
- R4: Bits 15..12 = 0010 (gap) reads a gap time from bits 19..0 of the addressed message word. Bits 31..20 are ignored. The next command starts once that many `bit_tick_i` pulses have been counted after the cycle in which `tx_done_i` ended the previous word.
- R5: Bits 15..12 = 0011 (fixed gap) works like R4, but the time is counted after the cycle in which `tx_req_o` rose for the previous word.
- R6: A gap time of 4 or less halts execution and sets `error_o`. `error_o` stays set through later runs until reset. A gap time of 5 is accepted.
- R7: Bits 15..12 = 0100 (pause) keeps the program counter in place, with `running_o` high, until a `resume_i` pulse arrives. Execution then continues at the next command.
- R8: Bits 15..12 = 0101 pulses `irq_o` high for exactly one cycle and continues with the next command.
- R9: Bits 15..12 = 0110 (jump) loads the program counter from bits 8..0. Stepping past address 511 wraps to address 0.
- R10: A `start_i` pulse while the program runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that starts the program at address 0 |
| resume_i | input | 1 | One-cycle pulse that releases a pause |
| bit_tick_i | input | 1 | One pulse per line bit period |
| sched_addr_o | output | 9 | Schedule memory read address |
| sched_data_i | input | 16 | Schedule memory data, one cycle after the address |
| msg_addr_o | output | 8 | Message memory read address |
| msg_data_i | input | 32 | Message memory data, one cycle after the address |
| tx_req_o | output | 1 | Transmit request, held until done |
| tx_word_o | output | 32 | Word to transmit |
| tx_done_i | input | 1 | Transmitter has finished the word |
| irq_o | output | 1 | One-cycle schedule interrupt |
| running_o | output | 1 | Program is executing |
| error_o | output | 1 | Sticky invalid-gap flag |

## Verification
The assertions check the following on every cycle: the request and its word stay steady until the handshake closes, the interrupt is never wider than one cycle, the error flag never clears and its rise coincides with a halt, the program counter does not move during a pause, jumps load the target and the counter wraps after 511, and the elapsed counters saturate instead of wrapping. Only the bench scenarios can show the rest: the exact number of bit ticks a gap or fixed gap spends before the next request, the words sent and their order, which opcodes halt, and that a start pulse during a run leaves the program's output unchanged.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  // Command kinds after decode; every reserved encoding maps to K_STOP.
  typedef enum logic [2:0] {
    K_STOP, K_MSG, K_GAP, K_FGAP, K_PAUSE, K_IRQ, K_JUMP
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_MREAD, S_MDATA, S_SEND, S_GAP, S_PAUSE
  } state_e;

  // Opcode field to command kind. Bit 3 set and 0111 are reserved.
  function automatic kind_e f_kind(input logic [3:0] op);
    kind_e k;
    case (op)
      4'h1:    k = K_MSG;
      4'h2:    k = K_GAP;
      4'h3:    k = K_FGAP;
      4'h4:    k = K_PAUSE;
      4'h5:    k = K_IRQ;
      4'h6:    k = K_JUMP;
      default: k = K_STOP;
    endcase
    return k;
  endfunction

  // A gap time is usable only above the rejection limit.
  function automatic logic f_gap_ok(input logic [31:0] gap, input logic [31:0] lim);
    return gap > lim;
  endfunction

  // Has the selected elapsed count reached the requested gap?
  function automatic logic f_gap_met(input logic [31:0] elapsed, input logic [31:0] gap);
    return elapsed >= gap;
  endfunction

endpackage

// File: rtl/tsq_decode.sv
module tsq_decode
  import tsq_pkg::*;
#(
  parameter int CMD_W   = 16,
  parameter int MADDR_W = 8,
  parameter int SADDR_W = 9
) (
  input  logic [CMD_W-1:0]   cmd_i,
  output kind_e              kind_o,
  output logic [MADDR_W-1:0] maddr_o,
  output logic [SADDR_W-1:0] target_o
);
  localparam int OP_LSB = CMD_W - 4;

  logic [3:0] op;
  logic       unused_bits;

  assign op          = cmd_i[CMD_W-1:OP_LSB];
  assign kind_o      = f_kind(op);
  assign maddr_o     = cmd_i[MADDR_W-1:0];
  assign target_o    = cmd_i[SADDR_W-1:0];
  assign unused_bits = ^cmd_i[OP_LSB-1:SADDR_W];

endmodule

// File: rtl/tsq_pc.sv
module tsq_pc #(
  parameter int SADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic               load_i,
  input  logic [SADDR_W-1:0] target_i,
  output logic [SADDR_W-1:0] pc_o
);
  localparam logic [SADDR_W-1:0] PC_TOP = '1;

  logic [SADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (clear_i) pc_q <= '0;
    else if (load_i)  pc_q <= target_i;
    else if (step_i)  pc_q <= pc_q + 1'b1;
  end

  assign pc_o = pc_q;

  // R9: a jump lands on the decoded target
  a_r9_jump_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !clear_i |=> pc_o == $past(target_i));

  // R9: stepping from the last address returns to zero
  a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i && !clear_i && pc_o == PC_TOP |=> pc_o == '0);

  // R7: without any control event the counter holds
  a_r7_pc_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i && !load_i && !clear_i |=> $stable(pc_o));

endmodule

// File: rtl/tsq_elapsed.sv
module tsq_elapsed #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // Clear wins over a tick in the same cycle; the count stops at its ceiling.
  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R4: a full counter never wraps back to small values
  a_r4_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o == CNT_MAX && !clear_i |=> cnt_o == CNT_MAX);

  // R4: without a tick the count does not move
  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !clear_i |=> $stable(cnt_o));

endmodule

// File: rtl/tsq_sequencer.sv
module tsq_sequencer
  import tsq_pkg::*;
#(
  parameter int SADDR_W     = 9,
  parameter int MADDR_W     = 8,
  parameter int CMD_W       = 16,
  parameter int MSG_W       = 32,
  parameter int GAP_W       = 20,
  parameter int GAP_MIN_BAD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               resume_i,
  input  logic               bit_tick_i,
  output logic [SADDR_W-1:0] sched_addr_o,
  input  logic [CMD_W-1:0]   sched_data_i,
  output logic [MADDR_W-1:0] msg_addr_o,
  input  logic [MSG_W-1:0]   msg_data_i,
  output logic               tx_req_o,
  output logic [MSG_W-1:0]   tx_word_o,
  input  logic               tx_done_i,
  output logic               irq_o,
  output logic               running_o,
  output logic               error_o
);

  state_e state_q, state_d;
  kind_e  dec_kind, kind_q;

  logic [MADDR_W-1:0] dec_maddr, maddr_q;
  logic [SADDR_W-1:0] dec_target, pc;
  logic [MSG_W-1:0]   word_q;
  logic [GAP_W-1:0]   gap_q, cnt_end, cnt_start, elapsed_sel, gap_field;
  logic               irq_q, err_q;

  // Named internal events
  logic ev_start, ev_send_begin, ev_send_end, ev_gap_bad, ev_gap_met;
  logic ev_resume, ev_irq, ev_jump, ev_is_gap, gap_valid;

  tsq_decode #(.CMD_W(CMD_W), .MADDR_W(MADDR_W), .SADDR_W(SADDR_W)) u_decode (
    .cmd_i    (sched_data_i),
    .kind_o   (dec_kind),
    .maddr_o  (dec_maddr),
    .target_o (dec_target)
  );

  assign gap_field = msg_data_i[GAP_W-1:0];
  assign gap_valid = f_gap_ok(32'(gap_field), 32'(GAP_MIN_BAD));
  assign ev_is_gap = (kind_q == K_GAP) || (kind_q == K_FGAP);

  assign ev_start      = start_i && (state_q == S_IDLE);
  assign ev_send_begin = (state_q == S_MDATA) && (kind_q == K_MSG);
  assign ev_send_end   = (state_q == S_SEND) && tx_done_i;
  assign ev_gap_bad    = (state_q == S_MDATA) && ev_is_gap && !gap_valid;
  assign elapsed_sel   = (kind_q == K_FGAP) ? cnt_start : cnt_end;
  assign ev_gap_met    = (state_q == S_GAP) && f_gap_met(32'(elapsed_sel), 32'(gap_q));
  assign ev_resume     = (state_q == S_PAUSE) && resume_i;
  assign ev_irq        = (state_q == S_DECODE) && (dec_kind == K_IRQ);
  assign ev_jump       = (state_q == S_DECODE) && (dec_kind == K_JUMP);

  tsq_pc #(.SADDR_W(SADDR_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (ev_start),
    .step_i   (ev_send_end | ev_gap_met | ev_resume | ev_irq),
    .load_i   (ev_jump),
    .target_i (dec_target),
    .pc_o     (pc)
  );

  // Time since the end of the latest word
  tsq_elapsed #(.CNT_W(GAP_W)) u_since_end (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (ev_start | ev_send_end),
    .tick_i  (bit_tick_i),
    .cnt_o   (cnt_end)
  );

  // Time since the start of the latest word
  tsq_elapsed #(.CNT_W(GAP_W)) u_since_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (ev_start | ev_send_begin),
    .tick_i  (bit_tick_i),
    .cnt_o   (cnt_start)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (ev_start) state_d = S_FETCH;
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (dec_kind)
          K_MSG, K_GAP, K_FGAP: state_d = S_MREAD;
          K_PAUSE:              state_d = S_PAUSE;
          K_IRQ, K_JUMP:        state_d = S_FETCH;
          default:              state_d = S_IDLE;
        endcase
      end
      S_MREAD:  state_d = S_MDATA;
      S_MDATA: begin
        if (kind_q == K_MSG) state_d = S_SEND;
        else if (ev_gap_bad) state_d = S_IDLE;
        else                 state_d = S_GAP;
      end
      S_SEND:   if (ev_send_end) state_d = S_FETCH;
      S_GAP:    if (ev_gap_met)  state_d = S_FETCH;
      S_PAUSE:  if (ev_resume)   state_d = S_FETCH;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_STOP;
      maddr_q <= '0;
      word_q  <= '0;
      gap_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= ev_irq;
      if (ev_gap_bad) err_q <= 1'b1;
      if (state_q == S_DECODE) begin
        kind_q  <= dec_kind;
        maddr_q <= dec_maddr;
      end
      if (ev_send_begin) word_q <= msg_data_i;
      if ((state_q == S_MDATA) && ev_is_gap) gap_q <= gap_field;
    end
  end

  assign sched_addr_o = pc;
  assign msg_addr_o   = maddr_q;
  assign tx_req_o     = (state_q == S_SEND);
  assign tx_word_o    = word_q;
  assign irq_o        = irq_q;
  assign running_o    = (state_q != S_IDLE);
  assign error_o      = err_q;

  // R2: request and word are held until the transmitter finishes
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o && !tx_done_i |=> tx_req_o && $stable(tx_word_o));

  // R1: an idle sequencer never requests a transmission
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !tx_req_o);

  // R8: the interrupt is a single-cycle pulse
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R6: the error flag never clears without reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> error_o);

  // R6: a new error coincides with a halted program
  a_r6_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> !running_o);

  // R7: a pause without resume keeps the schedule address
  a_r7_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_PAUSE && !resume_i |=> state_q == S_PAUSE && $stable(sched_addr_o));

  // R10: a start pulse during a run does not reset the schedule address
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    running_o && start_i && state_q == S_PAUSE && !resume_i |=> $stable(sched_addr_o));

endmodule

// File: tb/tsq_sequencer_tb.sv
module tsq_sequencer_tb_top;
  localparam int SADDR_W = 9;
  localparam int MADDR_W = 8;
  localparam int CMD_W   = 16;
  localparam int MSG_W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, resume_i = 1'b0, bit_tick_i = 1'b0, tx_done_i = 1'b0;
  logic [SADDR_W-1:0] sched_addr_o;
  logic [CMD_W-1:0]   sched_q = '0;
  logic [MADDR_W-1:0] msg_addr_o;
  logic [MSG_W-1:0]   msg_q = '0;
  logic               tx_req_o, irq_o, running_o, error_o;
  logic [MSG_W-1:0]   tx_word_o;

  always #10 clk = ~clk;

  tsq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resume_i(resume_i),
    .bit_tick_i(bit_tick_i), .sched_addr_o(sched_addr_o), .sched_data_i(sched_q),
    .msg_addr_o(msg_addr_o), .msg_data_i(msg_q), .tx_req_o(tx_req_o),
    .tx_word_o(tx_word_o), .tx_done_i(tx_done_i), .irq_o(irq_o),
    .running_o(running_o), .error_o(error_o)
  );

  logic [15:0] sched_mem [0:511];
  logic [31:0] msg_mem   [0:255];

  always @(posedge clk) begin
    sched_q <= sched_mem[sched_addr_o];
    msg_q   <= msg_mem[msg_addr_o];
  end

  int n_chk = 0, n_fail = 0;
  int log_n = 0, irq_cnt = 0;
  logic [31:0] log_w [0:63];
  int log_end [0:63];
  int log_start [0:63];
  int cnt_end = 0, cnt_start = 0, left = 0, div = 0;
  bit busy = 0, req_prev = 0, irq_prev = 0, start_req = 0, resume_req = 0, wrap_patch = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_word(input int a);
    return (32'h9E3779B9 * 32'(a + 1)) ^ 32'(a);
  endfunction
  function automatic int f_addr(input int k);
    return (k * 37 + 3) % 256;
  endfunction
  function automatic logic [15:0] c_op(input int op, input int arg);
    return 16'((op << 12) | arg);
  endfunction

  // Transmitter model, tick source and monitor, all on the falling edge
  always @(negedge clk) begin
    bit was_done;
    was_done  = tx_done_i;
    tx_done_i = 1'b0;
    if (rst_n) begin
      cnt_end   += int'(bit_tick_i);
      cnt_start += int'(bit_tick_i);
      if (start_i && !running_o) begin cnt_end = 0; cnt_start = 0; end
      if (was_done) cnt_end = 0;
      if (tx_req_o && !req_prev) begin
        if (log_n < 64) begin
          log_w[log_n]     = tx_word_o;
          log_end[log_n]   = cnt_end;
          log_start[log_n] = cnt_start;
        end
        log_n++;
        cnt_start = 0;
        busy = 1; left = 3;
        if (wrap_patch) begin sched_mem[0] = 16'h0000; wrap_patch = 0; end
      end else if (busy) begin
        left--;
        if (left == 0) begin tx_done_i = 1'b1; busy = 0; end
      end
      req_prev = tx_req_o;
      if (irq_o) begin
        irq_cnt++;
        if (irq_prev) chk(1'b0, "R8 irq width", 2, 1);
      end
      irq_prev = irq_o;
    end
    div = (div + 1) % 8;
    bit_tick_i = (div == 0);
    start_i    = start_req;  start_req  = 0;
    resume_i   = resume_req; resume_req = 0;
  end

  task automatic clear_sched();
    for (int i = 0; i < 512; i++) sched_mem[i] = 16'h0000;
  endtask

  task automatic kick();
    log_n = 0; irq_cnt = 0;
    @(posedge clk); #5; start_req = 1;
    repeat (3) @(posedge clk);
    #5;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #5;
      if (!running_o) break;
    end
  endtask

  task automatic run_prog();
    kick();
    wait_end();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) msg_mem[i] = f_word(i);
    clear_sched();
    repeat (4) @(posedge clk);
    #5;
    // R1: outputs in reset
    chk(running_o == 0, "R1 running in reset", running_o, 0);
    chk(tx_req_o == 0, "R1 req in reset", tx_req_o, 0);
    chk(irq_o == 0, "R1 irq in reset", irq_o, 0);
    chk(error_o == 0, "R1 error in reset", error_o, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    chk(running_o == 0, "R1 running after reset", running_o, 0);

    // R2: sequence of eight messages
    clear_sched();
    for (int k = 0; k < 8; k++) sched_mem[k] = c_op(1, f_addr(k));
    run_prog();
    chk(log_n == 8, "R2 message count", log_n, 8);
    for (int k = 0; k < 8; k++)
      chk(log_w[k] == f_word(f_addr(k)), "R2 message word", log_w[k], f_word(f_addr(k)));
    chk(running_o == 0, "R3 halt on 0000", running_o, 0);

    // R3: reserved encodings halt
    begin
      logic [15:0] rsv [3];
      rsv[0] = 16'h7ABC; rsv[1] = 16'h8001; rsv[2] = 16'hF0FF;
      for (int j = 0; j < 3; j++) begin
        clear_sched();
        sched_mem[0] = c_op(1, 10);
        sched_mem[1] = rsv[j];
        sched_mem[2] = c_op(1, 11);
        run_prog();
        chk(log_n == 1, "R3 reserved halts", log_n, 1);
      end
    end

    // R4: gap after end, sweep 5..12 (5 is the lowest accepted, R6)
    for (int g = 5; g <= 12; g++) begin
      msg_mem[200] = {12'hA5C, 20'(g)};
      clear_sched();
      sched_mem[0] = c_op(1, 1);
      sched_mem[1] = c_op(2, 200);
      sched_mem[2] = c_op(1, 2);
      run_prog();
      chk(log_n == 2, "R4 gap run count", log_n, 2);
      chk(log_end[1] == g, "R4 ticks after end", log_end[1], g);
    end
    chk(error_o == 0, "R6 gap of 5 accepted", error_o, 0);

    // R5: fixed gap from start, sweep 8..14
    for (int g = 8; g <= 14; g++) begin
      msg_mem[201] = {12'h3C3, 20'(g)};
      clear_sched();
      sched_mem[0] = c_op(1, 3);
      sched_mem[1] = c_op(3, 201);
      sched_mem[2] = c_op(1, 4);
      run_prog();
      chk(log_n == 2, "R5 fixed run count", log_n, 2);
      chk(log_start[1] == g, "R5 ticks after start", log_start[1], g);
    end

    // R7 and R10: pause, stray start, resume
    clear_sched();
    sched_mem[0] = c_op(1, 20);
    sched_mem[1] = c_op(4, 0);
    sched_mem[2] = c_op(1, 21);
    kick();
    repeat (100) @(posedge clk);
    #5;
    chk(log_n == 1, "R7 paused word count", log_n, 1);
    chk(running_o == 1, "R7 running while paused", running_o, 1);
    start_req = 1;
    repeat (50) @(posedge clk);
    #5;
    chk(log_n == 1, "R10 start ignored while running", log_n, 1);
    resume_req = 1;
    wait_end();
    chk(log_n == 2, "R7 resumed count", log_n, 2);
    chk(log_w[1] == f_word(21), "R7 word after resume", log_w[1], f_word(21));

    // R8: interrupts
    clear_sched();
    sched_mem[0] = c_op(5, 0);
    sched_mem[1] = c_op(5, 0);
    sched_mem[2] = c_op(1, 30);
    sched_mem[3] = c_op(5, 0);
    run_prog();
    chk(irq_cnt == 3, "R8 interrupt pulses", irq_cnt, 3);
    chk(log_n == 1, "R8 continues after interrupt", log_n, 1);

    // R9: jump to the top and wrap to zero
    clear_sched();
    sched_mem[0]   = c_op(6, 9'h1FE);
    sched_mem[1]   = c_op(1, 50);
    sched_mem[510] = c_op(1, 60);
    sched_mem[511] = c_op(1, 70);
    wrap_patch = 1;
    run_prog();
    chk(log_n == 2, "R9 jump word count", log_n, 2);
    chk(log_w[0] == f_word(60), "R9 jump target word", log_w[0], f_word(60));
    chk(log_w[1] == f_word(70), "R9 word before wrap", log_w[1], f_word(70));

    // R6: invalid gap halts and sticks
    msg_mem[202] = {12'hFFF, 20'd4};
    clear_sched();
    sched_mem[0] = c_op(1, 1);
    sched_mem[1] = c_op(2, 202);
    sched_mem[2] = c_op(1, 2);
    run_prog();
    chk(log_n == 1, "R6 halt on gap 4", log_n, 1);
    chk(error_o == 1, "R6 error set", error_o, 1);
    msg_mem[203] = 32'h0;
    clear_sched();
    sched_mem[0] = c_op(1, 5);
    sched_mem[1] = c_op(3, 203);
    sched_mem[2] = c_op(1, 6);
    run_prog();
    chk(log_n == 1, "R6 halt on fixed gap 0", log_n, 1);
    chk(error_o == 1, "R6 error sticky", error_o, 1);
    @(posedge clk); #5; rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    chk(error_o == 0, "R6 cleared by reset", error_o, 0);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule